// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a small 32-bit RISC datapath. Each cycle it takes an operation code and two operands. The second operand arrives already shifted, or as an expanded immediate. The block returns the operation's result, a write enable for the destination register, and a fresh set of negative, zero, carry and overflow flags together with a flag-update enable.

The operations are:
- Moves of the second operand, plain or inverted.
- Addition and subtraction in both operand orders.
- Carry-chained addition and subtraction.
- Bitwise AND, OR, XOR and clear-bits.
- Four test operations that only produce flags.

Subtraction treats the carry as an inverted borrow, so a carry of 1 means no borrow occurred. Logical operations take their carry from the shifter. They leave overflow at its incoming value.

Outputs are registered, so results appear one clock after the inputs are presented. Reset clears every output. The shifter, register file and decoder sit outside this block.

Top module: `alu_dp`

## Requirements
- R1: The operation code `op_i` maps as follows:

  | Code | Operation | Code | Operation |
  |---|---|---|---|
  | 0 | AND | 8 | TST |
  | 1 | EOR | 9 | TEQ |
  | 2 | SUB | 10 | CMP |
  | 3 | RSB | 11 | CMN |
  | 4 | ADD | 12 | ORR |
  | 5 | ADC | 13 | MOV |
  | 6 | SBC | 14 | BIC |
  | 7 | RSC | 15 | MVN |

  Inputs sampled on a rising edge of `clk` appear on the outputs right after that edge.
- R2: MOV gives `opb_i`. MVN gives `~opb_i`.
- R3: The arithmetic results are:
  - ADD gives a+b. ADC gives a+b+C.
  - SUB gives a-b. SBC gives a-b-(1-C).
  - RSB gives b-a. RSC gives b-a-(1-C).
  - Here a is `opa_i`, b is `opb_i` and C is `c_in_i`. All results are taken modulo 2^32.
- R4: The bitwise results are:
  - AND gives a&b.
  - EOR gives a^b.
  - ORR gives a|b.
  - BIC gives a&~b.
- R5: The four test operations compute the values of SUB, ADD, AND and EOR. TST uses AND, TEQ uses EOR, CMP uses SUB and CMN uses ADD. They present that value on `res_o` but hold `wr_o` low. Every other operation drives `wr_o` high.
- R6: `flg_o` is high for TST, TEQ, CMP and CMN regardless of `setf_i`. For every other operation, `flg_o` equals `setf_i`.
- R7: For arithmetic operations, `c_o` is the unsigned carry-out of the addition. A subtraction with no borrow gives 1. `v_o` is set exactly when the signed result falls outside the 32-bit signed range.
- R8: For bitwise, move and bit-test operations, `c_o` equals `shc_i` and `v_o` equals `v_in_i`.
- R9: `n_o` equals bit 31 of `res_o`. `z_o` is 1 exactly when `res_o` is zero.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (shifted or immediate) |
| c_in_i | input | 1 | Incoming carry flag |
| v_in_i | input | 1 | Incoming overflow flag |
| shc_i | input | 1 | Shifter carry-out |
| setf_i | input | 1 | Flag-update request |
| res_o | output | 32 | Result |
| wr_o | output | 1 | Result write enable |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |
| flg_o | output | 1 | Flag update enable |

## Verification
The bench targets the signed boundary at 0x7FFFFFFF/0x80000000, where a design that took overflow from the wrong operand order would flag reverse subtracts incorrectly. It also covers equal operands in subtraction, where a borrow-style carry would read 0 instead of 1. Carry-chained subtracts run with the carry both clear and set, to catch a design that treats the carry as a borrow rather than its inverse. Test operations are issued with `setf_i` low, to catch a design that writes the result or suppresses the flag update.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_SUB = 4'd2,
        OP_RSB = 4'd3,
        OP_ADD = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_RSC = 4'd7,
        OP_TST = 4'd8,
        OP_TEQ = 4'd9,
        OP_CMP = 4'd10,
        OP_CMN = 4'd11,
        OP_ORR = 4'd12,
        OP_MOV = 4'd13,
        OP_BIC = 4'd14,
        OP_MVN = 4'd15
    } alu_op_e;

    function automatic logic op_is_arith(input alu_op_e op);
        case (op)
            OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_is_test(input alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);
    localparam int unsigned MSB = W - 1;

    logic         swap;
    logic         inv;
    logic         cin_sel;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W:0]   total;

    always_comb begin
        swap    = (op == OP_RSB) || (op == OP_RSC);
        inv     = (op == OP_SUB) || (op == OP_RSB) || (op == OP_SBC) ||
                  (op == OP_RSC) || (op == OP_CMP);
        case (op)
            OP_SUB, OP_RSB, OP_CMP: cin_sel = 1'b1;
            OP_ADC, OP_SBC, OP_RSC: cin_sel = cin;
            default:                cin_sel = 1'b0;
        endcase
        x     = swap ? b : a;
        y     = inv ? ~(swap ? a : b) : (swap ? a : b);
        total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin_sel};
        sum   = total[MSB:0];
        cout  = total[W];
        ovf   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            OP_AND, OP_TST: y = a & b;
            OP_EOR, OP_TEQ: y = a ^ b;
            OP_ORR:         y = a | b;
            OP_MOV:         y = b;
            OP_BIC:         y = a & ~b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end
endmodule

// File: rtl/alu_dp.sv
module alu_dp
    import alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         c_in_i,
    input  logic         v_in_i,
    input  logic         shc_i,
    input  logic         setf_i,
    output logic [W-1:0] res_o,
    output logic         wr_o,
    output logic         n_o,
    output logic         z_o,
    output logic         c_o,
    output logic         v_o,
    output logic         flg_o
);
    localparam int unsigned MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         wr;
        logic         n;
        logic         z;
        logic         c;
        logic         v;
        logic         flg;
    } out_t;

    alu_op_e      op;
    logic [W-1:0] arith_sum;
    logic         arith_c;
    logic         arith_v;
    logic [W-1:0] logic_y;
    out_t         out_d;
    out_t         out_q;

    assign op = alu_op_e'(op_i);

    alu_arith #(.W(W)) u_arith (
        .op   (op),
        .a    (opa_i),
        .b    (opb_i),
        .cin  (c_in_i),
        .sum  (arith_sum),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    alu_logic #(.W(W)) u_logic (
        .op (op),
        .a  (opa_i),
        .b  (opb_i),
        .y  (logic_y)
    );

    always_comb begin
        logic arith;
        arith     = op_is_arith(op);
        out_d.res = arith ? arith_sum : logic_y;
        out_d.wr  = !op_is_test(op);
        out_d.flg = op_is_test(op) || setf_i;
        out_d.n   = out_d.res[MSB];
        out_d.z   = (out_d.res == '0);
        out_d.c   = arith ? arith_c : shc_i;
        out_d.v   = arith ? arith_v : v_in_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o = out_q.res;
    assign wr_o  = out_q.wr;
    assign n_o   = out_q.n;
    assign z_o   = out_q.z;
    assign c_o   = out_q.c;
    assign v_o   = out_q.v;
    assign flg_o = out_q.flg;

endmodule

// File: rtl/alu_dp_chk.sv
module alu_dp_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic [W-1:0] opb_i,
    input logic         v_in_i,
    input logic         shc_i,
    input logic         setf_i,
    input logic [W-1:0] res_o,
    input logic         wr_o,
    input logic         n_o,
    input logic         z_o,
    input logic         c_o,
    input logic         v_o,
    input logic         flg_o
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R5: test operations never write
    p_test_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && op_i[3:2] == 2'b10) |=> !wr_o);

    // R6: test operations always update flags
    p_test_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && op_i[3:2] == 2'b10) |=> flg_o);

    // R6: non-test with no request leaves flags alone
    p_noset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && op_i[3:2] != 2'b10 && !setf_i) |=> (!flg_o && wr_o));

    // R9: N and Z follow the result
    p_nz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (n_o == res_o[W-1]) && (z_o == (res_o == '0)));

    // R8: bitwise ops take shifter carry and keep overflow
    p_logic_cv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (op_i inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15}))
        |=> (c_o == $past(shc_i)) && (v_o == $past(v_in_i)));

    // R2: move passes the second operand
    p_mov_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && op_i == 4'd13) |=> (res_o == $past(opb_i)));

    // R10: outputs clear while reset is held
    always_comb begin
        if (!rst_n) begin
            a_reset_r10: assert (res_o == '0 && !wr_o && !flg_o && !n_o && !z_o && !c_o && !v_o);
        end
    end
endmodule

bind alu_dp alu_dp_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .opb_i  (opb_i),
    .v_in_i (v_in_i),
    .shc_i  (shc_i),
    .setf_i (setf_i),
    .res_o  (res_o),
    .wr_o   (wr_o),
    .n_o    (n_o),
    .z_o    (z_o),
    .c_o    (c_o),
    .v_o    (v_o),
    .flg_o  (flg_o)
);

// File: tb/alu_dp_test.sv
module alu_dp_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        c_in_i = 1'b0;
    logic        v_in_i = 1'b0;
    logic        shc_i = 1'b0;
    logic        setf_i = 1'b0;
    logic [31:0] res_o;
    logic        wr_o, n_o, z_o, c_o, v_o, flg_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_dp uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .c_in_i(c_in_i), .v_in_i(v_in_i), .shc_i(shc_i), .setf_i(setf_i),
        .res_o(res_o), .wr_o(wr_o), .n_o(n_o), .z_o(z_o), .c_o(c_o),
        .v_o(v_o), .flg_o(flg_o)
    );

    typedef struct {
        logic [31:0] res;
        logic wr, n, z, c, v, flg;
        string tag;
    } exp_t;

    function automatic logic sgn_ovf(input longint s);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic exp_t model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                   input logic c, input logic v, input logic sh, input logic sf);
        exp_t e;
        longint sa, sb, ua, ub, bw, full;
        logic arith;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
        bw = c ? 0 : 1;
        arith = 1'b1;
        e.tag = "R3";
        case (op)
            4'd4, 4'd11: begin full = ua + ub;      e.c = full > 64'hFFFFFFFF; e.v = sgn_ovf(sa + sb); end
            4'd5:        begin full = ua + ub + (1 - bw); e.c = full > 64'hFFFFFFFF; e.v = sgn_ovf(sa + sb + (1 - bw)); end
            4'd2, 4'd10: begin full = ua - ub;      e.c = ua >= ub;        e.v = sgn_ovf(sa - sb); end
            4'd6:        begin full = ua - ub - bw; e.c = ua >= ub + bw;   e.v = sgn_ovf(sa - sb - bw); end
            4'd3:        begin full = ub - ua;      e.c = ub >= ua;        e.v = sgn_ovf(sb - sa); end
            4'd7:        begin full = ub - ua - bw; e.c = ub >= ua + bw;   e.v = sgn_ovf(sb - sa - bw); end
            default: begin
                arith = 1'b0; e.tag = "R4";
                case (op)
                    4'd0, 4'd8: full = ua & ub;
                    4'd1, 4'd9: full = ua ^ ub;
                    4'd12:      full = ua | ub;
                    4'd13:      begin full = ub;  e.tag = "R2"; end
                    4'd14:      full = ua & ~ub;
                    default:    begin full = longint'({32'd0, ~b}); e.tag = "R2"; end
                endcase
                e.c = sh; e.v = v;
            end
        endcase
        e.res = full[31:0];
        e.wr  = !(op >= 4'd8 && op <= 4'd11);
        e.flg = !e.wr || sf;
        e.n   = e.res[31];
        e.z   = (e.res == 32'd0);
        if (!arith) e.c = sh;
        return e;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s op=%0d a=%h b=%h: actual=%h expected=%h", req, what, op_i, opa_i, opb_i, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic c, input logic v, input logic sh, input logic sf);
        exp_t e;
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; c_in_i = c; v_in_i = v; shc_i = sh; setf_i = sf;
        e = model(op, a, b, c, v, sh, sf);
        @(negedge clk);
        check(e.tag, "res", res_o, e.res);
        check("R5", "wr", {31'd0, wr_o}, {31'd0, e.wr});
        check("R6", "flg", {31'd0, flg_o}, {31'd0, e.flg});
        check("R9", "n", {31'd0, n_o}, {31'd0, e.n});
        check("R9", "z", {31'd0, z_o}, {31'd0, e.z});
        check((op_i inside {[4'd2:4'd7], [4'd10:4'd11]}) ? "R7" : "R8", "c", {31'd0, c_o}, {31'd0, e.c});
        check((op_i inside {[4'd2:4'd7], [4'd10:4'd11]}) ? "R7" : "R8", "v", {31'd0, v_o}, {31'd0, e.v});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R10: reset state
        op_i = 4'd4; opa_i = 32'hFFFF_FFFF; opb_i = 32'd1; setf_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", "res", res_o, 32'd0);
        check("R10", "ctl", {25'd0, wr_o, flg_o, n_o, z_o, c_o, v_o, 1'b0}, 32'd0);
        rst_n = 1'b1;
        // R1: every code exercised on one pattern
        for (int k = 0; k < 16; k++) run(4'(k), 32'h0F0F_1234, 32'h00FF_00F0, 1'b1, 1'b0, 1'b1, 1'b1);
        // R7: signed boundary and borrow corners
        run(4'd4, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        run(4'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        run(4'd3, 32'h8000_0000, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        run(4'd3, 32'd1, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1);
        run(4'd2, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b1);
        run(4'd10, 32'd5, 32'd5, 1'b0, 1'b0, 1'b0, 1'b0);
        run(4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        run(4'd5, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        run(4'd6, 32'd7, 32'd7, 1'b0, 1'b0, 1'b0, 1'b1);
        run(4'd6, 32'd7, 32'd7, 1'b1, 1'b0, 1'b0, 1'b1);
        run(4'd7, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        run(4'd7, 32'd3, 32'd9, 1'b1, 1'b0, 1'b0, 1'b1);
        // R8: logical carry and overflow pass-through
        run(4'd8, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0, 1'b1, 1'b1, 1'b0);
        run(4'd9, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, 1'b0, 1'b0, 1'b0);
        run(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1);
        run(4'd15, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            if (($urandom % 8) == 0) ra = {ra[31], {31{ra[30]}}};
            if (($urandom % 8) == 0) rb = ra;
            run(4'($urandom), ra, rb, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule